// File: doc/BRIEF.md
# DMA Channel Event Interrupt Collector

This block gathers the completion events of sixteen DMA channels into one 32-bit pending word and raises a single level-sensitive interrupt request toward the processor. The channels form two groups of eight: a normal group and a dedicated group. Each channel sends two single-cycle pulses: one when half of its transfer is done, and one when the whole transfer has ended. Each pulse sets its own sticky bit in the pending word. The bit stays set until software acknowledges it by writing a one to it.

A second word of the same layout holds per-event interrupt enables. The request line is high when any event is both pending and enabled. Software reads the pending word and writes the same value back. This acknowledges exactly the events it has seen and leaves any event that arrived in the meantime untouched. Decoding a bit position back to a channel uses the position's rule: position p belongs to channel (p/2) mod 8. Whether p is below 16 selects the group.

Top module: `dma_irq_unit`

## Requirements
- R1: After reset the pending word, the enable word and the `irq` output are all zero.
- R2: A pulse on `norm_half_evt[c]` sets pending bit 2c. A pulse on `norm_end_evt[c]` sets pending bit 2c+1. The bit is set from the clock edge that samples the pulse onward.
- R3: A pulse on `ded_half_evt[c]` sets pending bit 16+2c. A pulse on `ded_end_evt[c]` sets pending bit 17+2c.
- R4: A write with `reg_sel`=0 clears every pending bit whose write-data bit is 1. Bits written as 0 keep their value. Writing all ones empties the word.
- R5: Writing back a value just read from the pending word clears exactly the bits that were set.
- R6: A write with `reg_sel`=1 loads the enable word with the write data. Each bit is taken independently. A read with `reg_sel`=1 returns the enable word.
- R7: A pending bit latches even while its enable bit is 0. Such a bit does not raise `irq`.
- R8: `irq` equals the OR over all 32 bits of (pending AND enable), delayed by one register stage.
- R9: When an event pulse and a write-1 clear hit the same pending bit in one cycle, the bit stays set.
- R10: A write to one word leaves the other word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| norm_half_evt | input | 8 | Half-done pulses, normal channels |
| norm_end_evt | input | 8 | End-done pulses, normal channels |
| ded_half_evt | input | 8 | Half-done pulses, dedicated channels |
| ded_end_evt | input | 8 | End-done pulses, dedicated channels |
| reg_sel | input | 1 | Word select: 0 pending, 1 enable |
| reg_wr | input | 1 | Write strobe for the selected word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Selected word, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two things can reach the same pending bit in one cycle: a fresh channel pulse, and software acknowledging an earlier occurrence of that event. The bench sets two adjacent bits first. It then fires a new pulse on one of them in the very cycle it writes ones to both. It reads back and expects only the re-fired bit to survive. The same collision is watched on every cycle by a property: any bit pulsed in one cycle must read as set in the next, whatever the write data was.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

   // word select encoding on reg_sel
   localparam logic SEL_PEND = 1'b0;
   localparam logic SEL_EN   = 1'b1;

   // event kinds inside a channel's bit pair
   localparam int KIND_HALF = 0;
   localparam int KIND_END  = 1;

   // groups inside the status word
   localparam int GRP_NORM = 0;
   localparam int GRP_DED  = 1;

   // position of one event in the status word
   function automatic int evt_pos(input int chans, input int grp,
                                  input int ch, input int kind);
      return grp * (2 * chans) + 2 * ch + kind;
   endfunction

endpackage

// File: rtl/irq_evt_map.sv
module irq_evt_map #(
   parameter int CHANS = 8,
   localparam int W = 4 * CHANS
) (
   input  logic [CHANS-1:0] norm_half,
   input  logic [CHANS-1:0] norm_end,
   input  logic [CHANS-1:0] ded_half,
   input  logic [CHANS-1:0] ded_end,
   output logic [W-1:0]     evt
);
   import dma_irq_pkg::*;

   for (genvar c = 0; c < CHANS; c++) begin : g_ch
      assign evt[evt_pos(CHANS, GRP_NORM, c, KIND_HALF)] = norm_half[c];
      assign evt[evt_pos(CHANS, GRP_NORM, c, KIND_END)]  = norm_end[c];
      assign evt[evt_pos(CHANS, GRP_DED,  c, KIND_HALF)] = ded_half[c];
      assign evt[evt_pos(CHANS, GRP_DED,  c, KIND_END)]  = ded_end[c];
   end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic         ack_wr,
   input  logic [W-1:0] ack_mask,
   output logic [W-1:0] pend
);
   for (genvar b = 0; b < W; b++) begin : g_bit
      logic bit_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (evt[b])
            bit_q <= 1'b1;          // a new event beats an acknowledge
         else if (ack_wr && ack_mask[b])
            bit_q <= 1'b0;
      end
      assign pend[b] = bit_q;
   end
endmodule

// File: rtl/irq_en_bank.sv
module irq_en_bank #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] en
);
   logic [W-1:0] en_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         en_q <= '0;
      else if (wr)
         en_q <= wdata;
   end

   assign en = en_q;
endmodule

// File: rtl/irq_line_gen.sv
module irq_line_gen #(
   parameter int W = 32,
   parameter bit REGISTERED = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pend,
   input  logic [W-1:0] en,
   output logic         irq
);
   logic any_live;
   assign any_live = |(pend & en);

   if (REGISTERED) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= any_live;
      end
      assign irq = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq = any_live;
   end
endmodule

// File: rtl/dma_irq_unit.sv
module dma_irq_unit #(
   parameter int CHANS = 8,
   parameter bit IRQ_REGISTERED = 1'b1,
   localparam int W = 4 * CHANS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CHANS-1:0] norm_half_evt,
   input  logic [CHANS-1:0] norm_end_evt,
   input  logic [CHANS-1:0] ded_half_evt,
   input  logic [CHANS-1:0] ded_end_evt,
   input  logic             reg_sel,
   input  logic             reg_wr,
   input  logic [W-1:0]     reg_wdata,
   output logic [W-1:0]     reg_rdata,
   output logic             irq
);
   import dma_irq_pkg::*;

   if (CHANS < 1) begin : g_bad_chans
      $error("dma_irq_unit: CHANS must be at least 1");
   end

   logic [W-1:0] evt_all;
   logic [W-1:0] pend_q;
   logic [W-1:0] en_q;
   logic         pend_wr;
   logic         en_wr;

   assign pend_wr = reg_wr && (reg_sel == SEL_PEND);
   assign en_wr   = reg_wr && (reg_sel == SEL_EN);

   irq_evt_map #(.CHANS(CHANS)) u_map (
      .norm_half (norm_half_evt),
      .norm_end  (norm_end_evt),
      .ded_half  (ded_half_evt),
      .ded_end   (ded_end_evt),
      .evt       (evt_all)
   );

   irq_pend_bank #(.W(W)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_all),
      .ack_wr   (pend_wr),
      .ack_mask (reg_wdata),
      .pend     (pend_q)
   );

   irq_en_bank #(.W(W)) u_en (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (en_wr),
      .wdata (reg_wdata),
      .en    (en_q)
   );

   irq_line_gen #(.W(W), .REGISTERED(IRQ_REGISTERED)) u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend_q),
      .en    (en_q),
      .irq   (irq)
   );

   assign reg_rdata = (reg_sel == SEL_EN) ? en_q : pend_q;
endmodule

// File: rtl/dma_irq_unit_chk.sv
module dma_irq_unit_chk #(
   parameter int CHANS = 8,
   parameter bit IRQ_REGISTERED = 1'b1,
   localparam int W = 4 * CHANS
) (
   input logic         clk,
   input logic         rst_n,
   input logic         reg_sel,
   input logic         reg_wr,
   input logic [W-1:0] reg_wdata,
   input logic [W-1:0] evt_vec,
   input logic [W-1:0] pend_q,
   input logic [W-1:0] en_q,
   input logic         irq
);
   // R9
   evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_vec) |=> ((pend_q & $past(evt_vec)) == $past(evt_vec)));

   // R4
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_sel) |=> ((pend_q & $past(reg_wdata) & ~$past(evt_vec)) == '0));

   // R10
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && !reg_sel) |=> (pend_q == ($past(pend_q) | $past(evt_vec))));

   // R10
   en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_sel) |=> $stable(en_q));

   // R6
   en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel) |=> (en_q == $past(reg_wdata)));

   if (IRQ_REGISTERED) begin : g_irq_chk
      // R8
      irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == $past(|(pend_q & en_q))));
   end
endmodule

bind dma_irq_unit dma_irq_unit_chk #(.CHANS(CHANS), .IRQ_REGISTERED(IRQ_REGISTERED)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_sel   (reg_sel),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .evt_vec   (evt_all),
   .pend_q    (pend_q),
   .en_q      (en_q),
   .irq       (irq)
);

// File: tb/dma_irq_unit_bench.sv
`timescale 1ns/1ps
module dma_irq_unit_bench;
   localparam int CH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] ev_drv = '0;
   logic [CH-1:0] nh, ne, dh, de;
   logic        reg_sel = 1'b0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       tag;
   } sb_item_t;
   sb_item_t sb_q[$];

   always #4 clk = ~clk;

   // bit 2c/2c+1 normal half/end, 16+2c/17+2c dedicated half/end
   always_comb begin
      for (int c = 0; c < CH; c++) begin
         nh[c] = ev_drv[2*c];
         ne[c] = ev_drv[2*c+1];
         dh[c] = ev_drv[16+2*c];
         de[c] = ev_drv[17+2*c];
      end
   end

   dma_irq_unit u_dma_irq_unit (
      .clk(clk), .rst_n(rst_n),
      .norm_half_evt(nh), .norm_end_evt(ne),
      .ded_half_evt(dh), .ded_end_evt(de),
      .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq(irq)
   );

   // monitor: compare away from the rising edge
   always @(negedge clk) begin
      while (sb_q.size() > 0) begin
         sb_item_t it;
         logic [31:0] act;
         it  = sb_q.pop_front();
         act = it.is_irq ? {31'b0, irq} : reg_rdata;
         checks++;
         if (act !== it.exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
         end
      end
   end

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic wr(input logic sel, input logic [31:0] d);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      step();
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic pulse(input logic [31:0] ev);
      ev_drv = ev;
      step();
      ev_drv = '0;
   endtask

   task automatic pulse_ack(input logic [31:0] ev, input logic [31:0] d);
      ev_drv = ev; reg_sel = 1'b0; reg_wdata = d; reg_wr = 1'b1;
      step();
      ev_drv = '0; reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic chk_rd(input logic sel, input logic [31:0] exp, input string tag);
      sb_item_t it;
      reg_sel = sel;
      it.is_irq = 1'b0; it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      step();
   endtask

   task automatic chk_irq(input logic exp, input string tag);
      sb_item_t it;
      it.is_irq = 1'b1; it.exp = {31'b0, exp}; it.tag = tag;
      sb_q.push_back(it);
      step();
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  [TB] %0d tests run, %0d failed", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1; rst_n = 1'b1;
      // R1 reset state
      chk_rd(1'b0, 32'h0, "R1 pending");
      chk_rd(1'b1, 32'h0, "R1 enable");
      chk_irq(1'b0, "R1 irq");

      // R2 normal half ch3 (bit6), end ch5 (bit11); R7 no enable
      pulse(32'h0000_0840);
      chk_rd(1'b0, 32'h0000_0840, "R2 normal bits");
      chk_irq(1'b0, "R7 disabled pending");
      // R3 dedicated half ch0 (bit16), end ch7 (bit31)
      pulse(32'h8001_0000);
      chk_rd(1'b0, 32'h8001_0840, "R3 dedicated bits");

      // R6/R8 enable bit6: irq one stage later
      wr(1'b1, 32'h0000_0040);
      chk_irq(1'b0, "R8 lag before");
      chk_irq(1'b1, "R8 asserted");
      chk_rd(1'b1, 32'h0000_0040, "R6 enable readback");
      chk_rd(1'b0, 32'h8001_0840, "R10 pending after enable write");

      // R4 clear only bit11
      wr(1'b0, 32'h0000_0800);
      chk_rd(1'b0, 32'h8001_0040, "R4 partial clear");
      chk_rd(1'b1, 32'h0000_0040, "R10 enable after pending write");
      // R5 write back what was read
      wr(1'b0, 32'h8001_0040);
      chk_irq(1'b1, "R8 still high one cycle");
      chk_irq(1'b0, "R8 dropped");
      chk_rd(1'b0, 32'h0, "R5 readback ack");

      // R9 collision: set bits 2,3 then re-fire bit2 while acking both
      pulse(32'h0000_000C);
      pulse_ack(32'h0000_0004, 32'h0000_000C);
      chk_rd(1'b0, 32'h0000_0004, "R9 event wins");
      // R4 writing zero changes nothing
      wr(1'b0, 32'h0);
      chk_rd(1'b0, 32'h0000_0004, "R4 zero write");
      wr(1'b0, 32'hFFFF_FFFF);
      chk_rd(1'b0, 32'h0, "R4 clear all");

      // R8 dedicated end ch7 with enable
      wr(1'b1, 32'h8000_0000);
      pulse(32'h8000_0000);
      chk_irq(1'b0, "R8 dedicated lag");
      chk_irq(1'b1, "R8 dedicated raised");
      wr(1'b0, 32'hFFFF_FFFF);
      wr(1'b1, 32'hFFFF_FFFF);
      chk_irq(1'b0, "R7 all enabled, none pending");

      // R2/R3 sweep every channel and kind
      for (int c = 0; c < CH; c++) begin
         for (int k = 0; k < 4; k++) begin
            int p;
            p = ((k >= 2) ? 16 : 0) + 2 * c + (k & 1);
            pulse(32'h1 << p);
            chk_rd(1'b0, 32'h1 << p, (k < 2) ? "R2 sweep" : "R3 sweep");
            wr(1'b0, 32'hFFFF_FFFF);
         end
      end

      step();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
   end
endmodule